// File: doc/BRIEF.md
# Character-Time Receive Gap Timer

This block raises a receive-timeout flag once the serial line has stayed quiet for a programmed number of whole character times. Software or a protocol engine programs the gap in characters, for example the minimum silence between packets that a framed industrial protocol requires. The block works out how many bit times one character takes from the active serial format: one start bit, the data bits, an optional parity bit and one or two stop bits.

Two down-counters are chained. The first counts bit-time ticks from an external baud generator. It reloads with the frame length and gives one pulse per character time. The second counter is loaded with the programmed character count and steps down on each of those pulses. When it runs out, the flag is set. The receiver reports the end of each stop bit, which arms and restarts the timer. It also reports each detected start bit, which disarms the timer. The flag works the same way whether the surrounding port runs full-duplex or half-duplex.

Top module: `chartime_rx_timeout`

## Requirements
- R1: The frame length is F = 1 + D + P + S. D = 5 + `data_sel`, with `data_sel` 0,1,2,3 meaning 5,6,7,8 data bits. P = 1 when `parity_en` is high. S = 2 when `two_stop` is high, and 1 otherwise.
- R2: After an `rx_stop_end` pulse with `gap_chars` = N ≠ 0, `gap_timeout` stays low through the first N·F−1 `bit_tick` pulses. It is high one cycle after the clock edge that samples the N·F-th tick.
- R3: With 8 data bits, parity on, one stop bit and N = 3, the flag rises after exactly 33 bit ticks.
- R4: When `gap_chars` is 0 at the `rx_stop_end` pulse, the timer is not armed and `gap_timeout` never asserts, however many ticks follow.
- R5: Once set, `gap_timeout` stays high through any further ticks. It is cleared only by `rx_stop_end`, `rx_start` or `gap_clear`, one cycle after the pulse.
- R6: An `rx_start` pulse clears the flag and disarms the timer. No flag appears until the next `rx_stop_end`.
- R7: An `rx_stop_end` pulse during a running gap reloads both counters, so a full N·F ticks are needed again. A tick in the same cycle as `rx_stop_end` is not counted.
- R8: A `gap_clear` pulse drops the flag and disarms the timer.
- R9: After reset, `gap_timeout` is low and the timer is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| rx_stop_end | input | 1 | Pulse at the trailing edge of a received stop bit |
| rx_start | input | 1 | Pulse when a start bit is detected |
| gap_clear | input | 1 | Explicit flag clear pulse |
| data_sel | input | 2 | Data bits minus 5 |
| parity_en | input | 1 | Parity bit present |
| two_stop | input | 1 | Two stop bits |
| gap_chars | input | CHAR_W | Gap length in character times, 0 disables |
| gap_timeout | output | 1 | Receive gap timeout flag |

## Verification
A wrong frame length or a miscounting bit divider shifts the flag's rising edge by whole bit ticks, or by multiples of N ticks. The bench therefore checks the flag exactly one tick before and exactly at N·F, for every format and several counts. Stale counter contents after a reload show up as an early flag on the next gap, within one character time. A lost disarm shows up as a spurious flag after a long run of idle ticks.

// File: rtl/chartime_pkg.sv
package chartime_pkg;
   localparam int FRAME_W = 4;
   typedef logic [FRAME_W-1:0] frame_len_t;
endpackage

// File: rtl/chartime_frame_len.sv
module chartime_frame_len
   import chartime_pkg::*;
#(
   parameter bit ALLOW_TWO_STOP = 1'b1
) (
   input  logic [1:0] data_sel,
   input  logic       parity_en,
   input  logic       two_stop,
   output frame_len_t frame_len
);
   frame_len_t stop_bits;

   generate
      if (ALLOW_TWO_STOP) begin : g_stop_sel
         assign stop_bits = two_stop ? frame_len_t'(2) : frame_len_t'(1);
      end else begin : g_stop_one
         logic unused_two_stop;
         assign unused_two_stop = two_stop;
         assign stop_bits = frame_len_t'(1);
      end
   endgenerate

   // start(1) + data(5+sel) + parity + stop
   assign frame_len = frame_len_t'(6) + frame_len_t'(data_sel)
                    + frame_len_t'(parity_en) + stop_bits;

   // R1
   always_comb frame_range_chk: assert (frame_len >= 4'd7 && frame_len <= 4'd12);
endmodule

// File: rtl/chartime_bit_div.sv
module chartime_bit_div
   import chartime_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       reload,
   input  logic       run,
   input  logic       bit_tick,
   input  frame_len_t frame_len,
   output logic       char_pulse
);
   frame_len_t bits_left;

   assign char_pulse = run && !reload && bit_tick && (bits_left == frame_len_t'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         bits_left <= frame_len_t'(1);
      else if (reload)
         bits_left <= frame_len;
      else if (run && bit_tick) begin
         if (bits_left == frame_len_t'(1))
            bits_left <= frame_len;
         else
            bits_left <= bits_left - frame_len_t'(1);
      end
   end

   // R2
   bits_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bits_left != '0);
endmodule

// File: rtl/chartime_char_cnt.sv
module chartime_char_cnt #(
   parameter int CHAR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reload,
   input  logic [CHAR_W-1:0] load_val,
   input  logic              char_pulse,
   output logic              expire
);
   logic [CHAR_W-1:0] chars_left;

   assign expire = char_pulse && (chars_left == CHAR_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         chars_left <= '0;
      else if (reload)
         chars_left <= load_val;
      else if (char_pulse && chars_left != '0)
         chars_left <= chars_left - CHAR_W'(1);
   end

   // R2
   pulse_on_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      char_pulse |-> chars_left != '0);
endmodule

// File: rtl/chartime_rx_timeout.sv
module chartime_rx_timeout
   import chartime_pkg::*;
#(
   parameter int CHAR_W         = 4,
   parameter bit ALLOW_TWO_STOP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_tick,
   input  logic              rx_stop_end,
   input  logic              rx_start,
   input  logic              gap_clear,
   input  logic [1:0]        data_sel,
   input  logic              parity_en,
   input  logic              two_stop,
   input  logic [CHAR_W-1:0] gap_chars,
   output logic              gap_timeout
);
   initial begin
      if (CHAR_W < 1 || CHAR_W > 16)
         $error("CHAR_W out of range 1..16");
   end

   frame_len_t frame_len;
   logic       armed;
   logic       char_pulse;
   logic       expire;
   logic       reload;

   assign reload = rx_stop_end || rx_start;

   chartime_frame_len #(.ALLOW_TWO_STOP(ALLOW_TWO_STOP)) frame_i (
      .data_sel (data_sel),
      .parity_en(parity_en),
      .two_stop (two_stop),
      .frame_len(frame_len)
   );

   chartime_bit_div bit_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .reload    (reload),
      .run       (armed),
      .bit_tick  (bit_tick),
      .frame_len (frame_len),
      .char_pulse(char_pulse)
   );

   chartime_char_cnt #(.CHAR_W(CHAR_W)) char_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .reload    (reload),
      .load_val  (gap_chars),
      .char_pulse(char_pulse),
      .expire    (expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed       <= 1'b0;
         gap_timeout <= 1'b0;
      end else begin
         if (rx_start)
            armed <= 1'b0;
         else if (rx_stop_end)
            armed <= (gap_chars != '0);
         else if (gap_clear || expire)
            armed <= 1'b0;

         if (reload || gap_clear)
            gap_timeout <= 1'b0;
         else if (expire)
            gap_timeout <= 1'b1;
      end
   end

   // R2
   rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gap_timeout) |-> $past(bit_tick) && $past(armed));
   // R4
   zero_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_stop_end && !rx_start && gap_chars == '0) |=> !armed);
   // R5
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gap_timeout && !rx_stop_end && !rx_start && !gap_clear) |=> gap_timeout);
   // R6
   start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_start |=> !gap_timeout && !armed);
   // R8
   clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gap_clear && !rx_stop_end) |=> !gap_timeout && !armed);
endmodule

// File: tb/chartime_rx_timeout_tb.sv
module chartime_rx_timeout_tb_top;
   localparam int CW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bit_tick = 1'b0, rx_stop_end = 1'b0, rx_start = 1'b0, gap_clear = 1'b0;
   logic [1:0]    data_sel = 2'd3;
   logic          parity_en = 1'b1, two_stop = 1'b0;
   logic [CW-1:0] gap_chars = 4'd3;
   logic          gap_timeout;
   int            checks = 0, errors = 0;
   bit            done = 1'b0;

   always #2 clk = ~clk;

   chartime_rx_timeout #(.CHAR_W(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_stop_end(rx_stop_end),
      .rx_start(rx_start), .gap_clear(gap_clear), .data_sel(data_sel),
      .parity_en(parity_en), .two_stop(two_stop), .gap_chars(gap_chars),
      .gap_timeout(gap_timeout)
   );

   task automatic chk(string req, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: gap_timeout=%b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) bit_tick = 1'b1;
         @(negedge clk) bit_tick = 1'b0;
      end
   endtask

   task automatic pulse(ref logic s);
      @(negedge clk) s = 1'b1;
      @(negedge clk) s = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R9 reset", gap_timeout, 1'b0);
      rst_n = 1'b1;
      ticks(50);
      chk("R9 idle after reset", gap_timeout, 1'b0);

      // R1 R2: sweep every format and several counts
      for (int d = 0; d < 4; d++)
         for (int p = 0; p < 2; p++)
            for (int s = 0; s < 2; s++)
               for (int n = 1; n <= 3; n++) begin
                  int f;
                  data_sel = 2'(d); parity_en = p[0]; two_stop = s[0];
                  gap_chars = CW'(n);
                  f = 1 + 5 + d + p + 1 + s;
                  pulse(rx_stop_end);
                  ticks(n * f - 1);
                  chk("R1/R2 before", gap_timeout, 1'b0);
                  ticks(1);
                  chk("R1/R2 at", gap_timeout, 1'b1);
                  pulse(gap_clear);
                  chk("R8 clear", gap_timeout, 1'b0);
                  ticks(2 * f);
                  chk("R8 disarmed", gap_timeout, 1'b0);
               end

      // R2 largest count, 12-bit frame
      data_sel = 2'd3; parity_en = 1'b1; two_stop = 1'b1; gap_chars = 4'd15;
      pulse(rx_stop_end);
      ticks(179);
      chk("R2 max before", gap_timeout, 1'b0);
      ticks(1);
      chk("R2 max at", gap_timeout, 1'b1);

      // R3 and R7: 8E1, N=3, restart mid gap with a coincident tick
      data_sel = 2'd3; parity_en = 1'b1; two_stop = 1'b0; gap_chars = 4'd3;
      pulse(rx_stop_end);
      chk("R5 stop clears", gap_timeout, 1'b0);
      ticks(20);
      @(negedge clk) begin rx_stop_end = 1'b1; bit_tick = 1'b1; end
      @(negedge clk) begin rx_stop_end = 1'b0; bit_tick = 1'b0; end
      ticks(32);
      chk("R7/R3 before 33", gap_timeout, 1'b0);
      ticks(1);
      chk("R3 at 33", gap_timeout, 1'b1);

      // R5 hold
      ticks(60);
      chk("R5 hold", gap_timeout, 1'b1);

      // R6 start clears and disarms
      pulse(rx_start);
      chk("R6 start clears", gap_timeout, 1'b0);
      ticks(120);
      chk("R6 disarmed", gap_timeout, 1'b0);

      // R6 start mid gap
      pulse(rx_stop_end);
      ticks(10);
      pulse(rx_start);
      ticks(120);
      chk("R6 mid gap", gap_timeout, 1'b0);

      // R4 zero count
      gap_chars = 4'd0;
      pulse(rx_stop_end);
      ticks(300);
      chk("R4 zero", gap_timeout, 1'b0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not end, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule